// File: doc/BRIEF.md
# Two-Phase Transition-Signalled Latch Pipeline

This block is a linear FIFO built from a parameterised chain of self-timed stages. Each stage has a data latch, a latch for its request bit (the stage "done" bit), and a single enable gate. A stage's latch stays open while the stage is empty. It closes as soon as the stage's own done bit toggles to capture a new item, and it reopens once the following stage has toggled its own done bit to show that it has taken the item. The enable is the XNOR of a stage's done bit and the next stage's done bit. So one open/close pulse passes through each latch per data item.

Both channels use two-phase signalling, so every toggle of a request or an acknowledge marks one data item, in either direction of the edge. The producer may toggle `req_in` when `ack_out` equals `req_in`, and it must hold `data_in` steady until `ack_out` follows. The consumer sees a new item whenever `req_out` differs from `ack_in`, and it releases the item by toggling `ack_in`. For cycle-level simulation and synthesis, each latch is modelled as a register that advances on a step clock, so one stage is passed per step. A parameter can insert a matched delay of `REQ_DLY` steps on the request between neighbouring stages. This models the bundled-data rule that a request arrives only after the data is stable.

Top module: `twophase_latch_fifo`

## Requirements
- R1: While `rst_n` is low and after it is released, `ack_out`, `req_out` and `data_out` are 0, and every stage is empty and open.
- R2: When stage 0 is empty, `ack_out` takes the value of `req_in` on the first clock edge after `req_in` toggles. `ack_out` never changes to any value other than the `req_in` value sampled at that edge.
- R3: With the pipeline empty and the output idle, `req_out` toggles on the edge numbered N_STAGES + (N_STAGES-1)*REQ_DLY after the toggle of `req_in`, counting from that toggle.
- R4: Items leave in the order they entered, with unchanged values, for both rising and falling request edges, under any consumer acknowledge delay.
- R5: With `ack_in` held, exactly N_STAGES items are accepted. A further request stays unacknowledged (`ack_out` != `req_in`).
- R6: While the pipeline is full and `req_in` does not toggle, changes on `data_in` leave `data_out` and `req_out` unchanged.
- R7: When the pipeline is empty, the latches are open: a change on `data_in` with no request toggle reaches `data_out` after N_STAGES edges, and `req_out` stays unchanged.
- R8: A stage accepts at most one item every two edges. A producer and consumer that respond at once see `ack_out` toggle exactly every second edge.
- R9: A stage's done bit changes only when the stage was empty (its done bit equalled the next stage's done bit). On a full pipeline, a single toggle of `ack_in` frees room for exactly one further item.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Step clock; one latch hop per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_in | input | 1 | Input channel request, toggles once per item |
| ack_out | output | 1 | Input channel acknowledge (done bit of stage 0) |
| data_in | input | W | Input channel data, held until acknowledged |
| req_out | output | 1 | Output channel request (done bit of last stage) |
| ack_in | input | 1 | Output channel acknowledge from consumer |
| data_out | output | W | Output channel data (last stage latch) |

## Verification
The bench targets the points where a transition-signalled pipeline goes wrong. It checks items of both request polarities under random consumer stalls, where a design that reads levels instead of toggles would drop or duplicate every other item. It fills the pipeline against a held acknowledge, where an enable built with the wrong polarity would overwrite a held item or accept one too many. It wiggles `data_in` on a full and on an empty pipeline: a latch that fails to close lets the new data overrun the held item, and a latch that fails to reopen stops the open data path. It also measures the exact latency and the two-edge rhythm at full speed, which show an extra or missing register in the request path.

// File: rtl/twophase_latch_fifo.sv
module twophase_latch_fifo #(
  parameter int N_STAGES = 4,
  parameter int W        = 8,
  parameter int REQ_DLY  = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_in,
  output logic         ack_out,
  input  logic [W-1:0] data_in,
  output logic         req_out,
  input  logic         ack_in,
  output logic [W-1:0] data_out
);

  localparam int LAST = N_STAGES - 1;

  logic [LAST:0] done;
  logic [LAST:0] req_at;
  logic [LAST:0] nxt;
  logic [W-1:0]  lat [N_STAGES];
  logic [W-1:0]  src [N_STAGES];

  assign ack_out  = done[0];
  assign req_out  = done[LAST];
  assign data_out = lat[LAST];

  for (genvar i = 0; i < N_STAGES; i++) begin : g_stage
    logic en;

    if (i == 0) begin : g_head
      assign req_at[i] = req_in;
      assign src[i]    = data_in;
    end else if (REQ_DLY == 0) begin : g_direct
      assign req_at[i] = done[i-1];
      assign src[i]    = lat[i-1];
    end else begin : g_matched
      logic [REQ_DLY-1:0] sh;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else begin
          sh[0] <= done[i-1];
          for (int k = 1; k < REQ_DLY; k++) sh[k] <= sh[k-1];
        end
      end
      assign req_at[i] = sh[REQ_DLY-1];
      assign src[i]    = lat[i-1];
    end

    if (i == LAST) begin : g_tail
      assign nxt[i] = ack_in;
    end else begin : g_mid
      assign nxt[i] = done[i+1];
    end

    assign en = done[i] ~^ nxt[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        done[i] <= 1'b0;
        lat[i]  <= '0;
      end else if (en) begin
        done[i] <= req_at[i];
        lat[i]  <= src[i];
      end
    end

    assert_fill_when_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (done[i] != $past(done[i])) |-> ($past(done[i]) == $past(nxt[i])));

    assert_hold_when_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(done[i]) != $past(nxt[i])) |-> ($stable(lat[i]) && $stable(done[i])));
  end

  assert_ack_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_out != $past(ack_out)) |-> (ack_out == $past(req_in)));

  assert_two_edge_rhythm_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_out != $past(ack_out)) |=> $stable(ack_out));

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |-> (!ack_out && !req_out && data_out == '0));

endmodule

// File: tb/sim_twophase_latch_fifo.sv
module sim_twophase_latch_fifo;
  localparam int N = 4;
  localparam int W = 8;
  localparam int D = 0;
  localparam int LAT = N + (N - 1) * D;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_in = 1'b0;
  logic ack_in = 1'b0;
  logic [W-1:0] data_in = '0;
  logic ack_out, req_out;
  logic [W-1:0] data_out;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  logic [W-1:0] q [$];

  twophase_latch_fifo #(.N_STAGES(N), .W(W), .REQ_DLY(D)) u0 (
    .clk(clk), .rst_n(rst_n), .req_in(req_in), .ack_out(ack_out),
    .data_in(data_in), .req_out(req_out), .ack_in(ack_in), .data_out(data_out)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain();
    for (int t = 0; t < 20 * (LAT + 2) && q.size() > 0; t++) begin
      @(negedge clk);
      if (req_out != ack_in) begin
        check("R4 drain order", data_out, q.pop_front());
        ack_in = ~ack_in;
      end
    end
    check("R4 drain complete", q.size(), 0);
  endtask

  task automatic t_reset();
    tick(3);
    check("R1 ack_out", ack_out, 0);
    check("R1 req_out", req_out, 0);
    check("R1 data_out", data_out, 0);
    rst_n = 1'b1;
    tick(2);
    check("R1 after release", {ack_out, req_out, data_out}, 0);
  endtask

  task automatic t_latency();
    int seen = 0;
    logic r0;
    r0 = req_out;
    data_in = 8'hC3;
    req_in = ~req_in;
    q.push_back(8'hC3);
    for (int c = 1; c <= LAT + 5; c++) begin
      @(negedge clk);
      if (c == 1) check("R2 ack_out follows req_in", ack_out, req_in);
      if (seen == 0 && req_out != r0) seen = c;
    end
    check("R3 latency edges", seen, LAT);
    drain();
  endtask

  task automatic t_stream(input int n, input int maxd);
    int got = 0;
    fork
      begin
        for (int k = 0; k < n; k++) begin
          while (ack_out != req_in) @(negedge clk);
          data_in = W'($urandom);
          q.push_back(data_in);
          req_in = ~req_in;
          @(negedge clk);
        end
      end
      begin
        while (got < n) begin
          @(negedge clk);
          if (req_out != ack_in) begin
            check("R4 order and value", data_out, q.pop_front());
            got++;
            tick($urandom_range(0, maxd));
            ack_in = ~ack_in;
          end
        end
      end
    join
    tick(2);
  endtask

  task automatic t_capacity();
    int acc = 0;
    logic [W-1:0] first;
    logic ro;
    for (int k = 0; k < N; k++) begin
      data_in = W'(8'h10 + k);
      q.push_back(data_in);
      req_in = ~req_in;
      for (int t = 0; t < 6 * LAT + 6 && ack_out != req_in; t++) @(negedge clk);
      if (ack_out == req_in) acc++;
      @(negedge clk);
    end
    check("R5 items accepted while stalled", acc, N);
    tick(LAT + 2);
    first = q[0];
    ro = req_out;
    for (int t = 0; t < 10; t++) begin
      data_in = W'($urandom);
      @(negedge clk);
    end
    check("R6 data_out held", data_out, first);
    check("R6 req_out held", req_out, ro);
    data_in = 8'hEE;
    q.push_back(data_in);
    req_in = ~req_in;
    tick(6 * LAT);
    check("R5 extra request unacknowledged", ack_out != req_in, 1);
    check("R4 head on stall", data_out, q.pop_front());
    ack_in = ~ack_in;
    tick(6 * LAT);
    check("R9 one slot freed", ack_out, req_in);
    drain();
  endtask

  task automatic t_transparent();
    logic ro;
    tick(LAT + 2);
    ro = req_out;
    data_in = 8'h5A;
    tick(N);
    check("R7 data passes open latches", data_out, 8'h5A);
    check("R7 req_out unchanged", req_out, ro);
  endtask

  task automatic t_rhythm();
    int last = -1;
    int bad = 0;
    int toggles = 0;
    logic a;
    fork
      begin
        for (int k = 0; k < 20; k++) begin
          while (ack_out != req_in) @(negedge clk);
          data_in = W'(k * 7);
          q.push_back(data_in);
          req_in = ~req_in;
          @(negedge clk);
        end
      end
      begin
        a = ack_out;
        for (int c = 0; c < 200 && toggles < 20; c++) begin
          @(negedge clk);
          if (req_out != ack_in) begin
            check("R4 full-speed order", data_out, q.pop_front());
            ack_in = ~ack_in;
          end
          if (ack_out != a) begin
            if (last >= 0 && c - last != 2) bad++;
            last = c;
            a = ack_out;
            toggles++;
          end
        end
      end
    join
    check("R8 two-edge rhythm violations", bad, 0);
    check("R8 items accepted", toggles, 20);
    drain();
  endtask

  initial begin
    t_reset();
    t_latency();
    t_stream(40, 3);
    t_capacity();
    t_transparent();
    t_rhythm();
    t_stream(20, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule